// File: doc/BRIEF.md
# Host Mailbox Port

This block is an 8-bit mailbox between an external host and the local CPU. The host has no clock. It selects the block with an active-low chip select and moves data with active-low write and read strobes. A single address bit picks either the data path or a second register. The host fills an inbound buffer that the CPU drains, and the CPU fills an outbound buffer that the host drains. Two handshake lines tell the host how far each transfer has got. An active-low line is low while inbound data waits for the CPU. An active-high line is high while outbound data waits for the host, and it can serve as the host's interrupt.

The block passes both host strobes through multi-flop synchronisers into the system clock and acts on the synchronised rising edge of each strobe. While a strobe is low, the block keeps capturing the host's address, select and data. When the strobe rises, it commits the last captured values. A data write raises a one-cycle interrupt pulse toward the CPU. A write with the address bit high is kept as a command byte and leaves the inbound handshake alone. A read with the address bit high returns a status byte. The read data bus is driven combinationally while select and read are both low.

Top module: `host_mailbox_port`

## Requirements
- R1: After reset, inFullN is 1, outFull is 0, cpuIrq is 0 and hostDataOe is 0.
- R2: A host write with hostCsN low and hostAddr 0 stores hostDataIn in the inbound buffer (cpuInData) and drives inFullN low within SYNC_STAGES+2 clocks after hostWrN rises. A write into a full buffer overwrites it.
- R3: Each committed host data write gives exactly one cpuIrq pulse, one clock wide, in the same cycle that inFullN falls. A command write gives no pulse.
- R4: A host write with hostCsN low and hostAddr 1 stores hostDataIn in cpuCmdData. It changes neither inFullN nor cpuInData.
- R5: Host strobes seen while hostCsN is high change no buffer and no flag, and hostDataOe stays 0.
- R6: A one-clock cpuInRd pulse returns inFullN to 1 on the next clock. A host data write committed in the same cycle wins.
- R7: A one-clock cpuOutWr pulse loads cpuOutData into the outbound buffer and sets outFull on the next clock. The CPU write wins over a host read that completes in the same cycle.
- R8: While hostCsN and hostRdN are both low, hostDataOe is 1. With hostAddr 0, hostDataOut shows the outbound buffer, and outFull is cleared within SYNC_STAGES+2 clocks after hostRdN rises. When hostDataOe is 0, hostDataOut is all zeros.
- R9: A host read with hostAddr 1 returns a status byte and leaves outFull unchanged. In that byte, bit 0 is 1 while the inbound buffer is full, bit 1 equals outFull, and all higher bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostAddr | input | 1 | Host register select: 0 data, 1 command/status |
| hostDataIn | input | DATA_W | Host write data |
| hostDataOut | output | DATA_W | Host read data, zero when not driven |
| hostDataOe | output | 1 | Host data bus output enable |
| inFullN | output | 1 | Inbound buffer holds unread data, active low |
| outFull | output | 1 | Outbound buffer holds data for the host (host interrupt) |
| cpuIrq | output | 1 | One-cycle pulse on each committed host data write |
| cpuInRd | input | 1 | CPU has read the inbound buffer |
| cpuInData | output | DATA_W | Inbound buffer contents |
| cpuCmdData | output | DATA_W | Last host command byte |
| cpuOutWr | input | 1 | CPU write strobe for the outbound buffer |
| cpuOutData | input | DATA_W | CPU data for the outbound buffer |

## Verification
The bench uses the default parameters: DATA_W of 8 and SYNC_STAGES of 2. At the 200 MHz clock, a 40 ns host strobe covers eight clocks, so the capture window and the commit edge are both exercised under realistic host timing. With only two synchroniser stages, a status read taken right after a CPU action shows the flags already settled. The command, status and chip-select-ignored paths are all reachable with a random mix of host and CPU operations.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic captureWr;  // host write strobe held low: track host data
    logic commitIn;   // move captured byte to inbound buffer
    logic commitCmd;  // move captured byte to command register
    logic loadOut;    // CPU loads outbound buffer
  } ctrlStrobes_t;
endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hpp_ctrl.sv
module hpp_ctrl
  import hpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostCsN,
  input  logic         hostWrN,
  input  logic         hostRdN,
  input  logic         hostAddr,
  input  logic         cpuInRd,
  input  logic         cpuOutWr,
  output ctrlStrobes_t strobes,
  output logic         inFull,
  output logic         outFull,
  output logic         cpuIrq
);
  logic wrSync, rdSync;
  logic wrPrev, rdPrev;
  logic wrAddrQ, wrCsNQ, rdAddrQ, rdCsNQ;
  logic wrRise, rdRise;
  logic clrOut;

  hpp_sync #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(clk), .rstN(rstN), .asyncIn(hostWrN), .syncOut(wrSync));
  hpp_sync #(.STAGES(SYNC_STAGES)) u_rdSync (
    .clk(clk), .rstN(rstN), .asyncIn(hostRdN), .syncOut(rdSync));

  // Edge history and address/select capture while each strobe is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b1;
      rdPrev  <= 1'b1;
      wrAddrQ <= 1'b0;
      wrCsNQ  <= 1'b1;
      rdAddrQ <= 1'b0;
      rdCsNQ  <= 1'b1;
    end else begin
      wrPrev <= wrSync;
      rdPrev <= rdSync;
      if (!wrSync) begin
        wrAddrQ <= hostAddr;
        wrCsNQ  <= hostCsN;
      end
      if (!rdSync) begin
        rdAddrQ <= hostAddr;
        rdCsNQ  <= hostCsN;
      end
    end
  end

  assign wrRise = wrSync & ~wrPrev;
  assign rdRise = rdSync & ~rdPrev;
  assign clrOut = rdRise & ~rdCsNQ & ~rdAddrQ;

  always_comb begin
    strobes.captureWr = ~wrSync;
    strobes.commitIn  = wrRise & ~wrCsNQ & ~wrAddrQ;
    strobes.commitCmd = wrRise & ~wrCsNQ & wrAddrQ;
    strobes.loadOut   = cpuOutWr;
  end

  // Handshake flags: setting events take priority over clearing events
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
      cpuIrq  <= 1'b0;
    end else begin
      cpuIrq <= strobes.commitIn;
      if (strobes.commitIn)  inFull <= 1'b1;
      else if (cpuInRd)      inFull <= 1'b0;
      if (cpuOutWr)          outFull <= 1'b1;
      else if (clrOut)       outFull <= 1'b0;
    end
  end
endmodule

// File: rtl/hpp_datapath.sv
module hpp_datapath
  import hpp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] cpuOutData,
  input  logic              hostAddr,
  input  logic              hostDataOe,
  input  logic              inFull,
  input  logic              outFull,
  output logic [DATA_W-1:0] hostDataOut,
  output logic [DATA_W-1:0] cpuInData,
  output logic [DATA_W-1:0] cpuCmdData
);
  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] inBuf;
  logic [DATA_W-1:0] cmdBuf;
  logic [DATA_W-1:0] outBuf;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      inBuf    <= '0;
      cmdBuf   <= '0;
      outBuf   <= '0;
    end else begin
      if (strobes.captureWr) holdData <= hostDataIn;
      if (strobes.commitIn)  inBuf    <= holdData;
      if (strobes.commitCmd) cmdBuf   <= holdData;
      if (strobes.loadOut)   outBuf   <= cpuOutData;
    end
  end

  assign statusByte  = {{PAD_W{1'b0}}, outFull, inFull};
  assign hostDataOut = !hostDataOe ? '0 : (hostAddr ? statusByte : outBuf);
  assign cpuInData   = inBuf;
  assign cpuCmdData  = cmdBuf;
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port
  import hpp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              inFullN,
  output logic              outFull,
  output logic              cpuIrq,
  input  logic              cpuInRd,
  output logic [DATA_W-1:0] cpuInData,
  output logic [DATA_W-1:0] cpuCmdData,
  input  logic              cpuOutWr,
  input  logic [DATA_W-1:0] cpuOutData
);
  ctrlStrobes_t strobes;
  logic         inFull;

  // Bus drive follows the raw host pins, no clock involved
  assign hostDataOe = ~hostCsN & ~hostRdN;
  assign inFullN    = ~inFull;

  hpp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostCsN(hostCsN), .hostWrN(hostWrN), .hostRdN(hostRdN), .hostAddr(hostAddr),
    .cpuInRd(cpuInRd), .cpuOutWr(cpuOutWr),
    .strobes(strobes), .inFull(inFull), .outFull(outFull), .cpuIrq(cpuIrq));

  hpp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostDataIn(hostDataIn), .cpuOutData(cpuOutData),
    .hostAddr(hostAddr), .hostDataOe(hostDataOe),
    .inFull(inFull), .outFull(outFull),
    .hostDataOut(hostDataOut), .cpuInData(cpuInData), .cpuCmdData(cpuCmdData));
endmodule

// File: rtl/host_mailbox_port_chk.sv
module host_mailbox_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuInRd,
  input logic              cpuOutWr,
  input logic              cpuIrq,
  input logic              inFullN,
  input logic              outFull,
  input logic              hostAddr,
  input logic              hostDataOe,
  input logic [DATA_W-1:0] hostDataOut
);
  localparam int PAD_W = DATA_W - 2;

  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |=> !cpuIrq);

  a_r3_irq_with_full: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> !inFullN);

  a_r2_full_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inFullN) |-> cpuIrq);

  a_r6_cpu_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    cpuInRd |=> (inFullN || cpuIrq));

  a_r7_cpu_write_sets: assert property (@(posedge clk) disable iff (!rstN)
    cpuOutWr |=> outFull);

  a_r8_bus_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hostDataOe |-> (hostDataOut == '0));

  a_r9_status_byte: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataOe && hostAddr) |-> (hostDataOut == {{PAD_W{1'b0}}, outFull, !inFullN}));
endmodule

bind host_mailbox_port host_mailbox_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_host_mailbox_port.sv
`timescale 1ns/100ps
module tb_host_mailbox_port;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostWrN = 1'b1, hostRdN = 1'b1, hostAddr = 1'b0;
  logic [DW-1:0] hostDataIn = '0;
  logic [DW-1:0] hostDataOut;
  logic hostDataOe, inFullN, outFull, cpuIrq;
  logic cpuInRd = 1'b0, cpuOutWr = 1'b0;
  logic [DW-1:0] cpuInData, cpuCmdData;
  logic [DW-1:0] cpuOutData = '0;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  bit done = 0;

  // Reference model state
  logic mInFull = 0, mOutFull = 0;
  logic [DW-1:0] mIn = '0, mCmd = '0, mOut = '0;

  always #2.5 clk = ~clk;

  host_mailbox_port dut (.*);

  always @(negedge clk) if (rstN && cpuIrq) irqCount++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expStatus(input logic inF, input logic outF);
    return {{(DW-2){1'b0}}, outF, inF};
  endfunction

  task automatic hostWrite(input logic a, input logic [DW-1:0] d, input logic sel);
    hostAddr = a; hostDataIn = d; hostCsN = ~sel;
    #3.3 hostWrN = 1'b0;
    #40  hostWrN = 1'b1;
    #20  hostCsN = 1'b1;
    #15;
    @(negedge clk);
  endtask

  task automatic hostRead(input logic a, input logic sel,
                          output logic [DW-1:0] d, output logic oe);
    hostAddr = a; hostCsN = ~sel;
    #3.3 hostRdN = 1'b0;
    #20.3 d = hostDataOut; oe = hostDataOe;
    #20  hostRdN = 1'b1;
    #20  hostCsN = 1'b1;
    #15;
    @(negedge clk);
  endtask

  task automatic cpuRead();
    @(negedge clk) cpuInRd = 1'b1;
    @(negedge clk) cpuInRd = 1'b0;
  endtask

  task automatic cpuWrite(input logic [DW-1:0] d);
    @(negedge clk) begin cpuOutWr = 1'b1; cpuOutData = d; end
    @(negedge clk) cpuOutWr = 1'b0;
  endtask

  task automatic checkModel(input string tag);
    chk({tag, " R2 inFullN"}, inFullN, !mInFull);
    chk({tag, " R2 inData"}, cpuInData, mIn);
    chk({tag, " R4 cmdData"}, cpuCmdData, mCmd);
    chk({tag, " R8 outFull"}, outFull, mOutFull);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic oe;
    int startIrq;
    int seed;
    seed = $urandom(32'h5eed);

    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 inFullN", inFullN, 1'b1);
    chk("R1 outFull", outFull, 1'b0);
    chk("R1 cpuIrq", cpuIrq, 1'b0);
    chk("R1 hostDataOe", hostDataOe, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: data write
    startIrq = irqCount;
    hostWrite(1'b0, 8'hA5, 1'b1); mInFull = 1; mIn = 8'hA5;
    checkModel("directed data write");
    chk("R3 one irq per data write", irqCount - startIrq, 1);

    // R4/R3: command write, no irq, no flag change
    startIrq = irqCount;
    hostWrite(1'b1, 8'h3C, 1'b1); mCmd = 8'h3C;
    checkModel("directed cmd write");
    chk("R3 no irq on cmd write", irqCount - startIrq, 0);

    // R5: deselected write ignored
    startIrq = irqCount;
    hostWrite(1'b0, 8'h11, 1'b0);
    checkModel("R5 deselected write");
    chk("R5 no irq", irqCount - startIrq, 0);

    // R2: overwrite while full
    hostWrite(1'b0, 8'h77, 1'b1); mIn = 8'h77;
    checkModel("R2 overwrite");

    // R9: status read
    hostRead(1'b1, 1'b1, rd, oe);
    chk("R9 status full/empty", rd, expStatus(1'b1, 1'b0));
    chk("R8 oe during read", oe, 1'b1);

    // R6: CPU read clears
    cpuRead(); mInFull = 0;
    chk("R6 inFullN after cpu read", inFullN, 1'b1);

    // R7: CPU write sets
    cpuWrite(8'h5A); mOut = 8'h5A; mOutFull = 1;
    chk("R7 outFull after cpu write", outFull, 1'b1);

    // R9: status read does not clear outFull
    hostRead(1'b1, 1'b1, rd, oe);
    chk("R9 status out only", rd, expStatus(1'b0, 1'b1));
    chk("R9 outFull kept", outFull, 1'b1);

    // R5: deselected read
    hostRead(1'b0, 1'b0, rd, oe);
    chk("R5 oe stays low", oe, 1'b0);
    chk("R5 outFull kept", outFull, 1'b1);

    // R8: data read
    hostRead(1'b0, 1'b1, rd, oe);
    chk("R8 read data", rd, 8'h5A);
    chk("R8 oe", oe, 1'b1);
    mOutFull = 0;
    chk("R8 outFull cleared", outFull, 1'b0);
    chk("R8 idle bus zero", hostDataOut, '0);

    // Random mix against the model
    for (int i = 0; i < 80; i++) begin
      int op;
      logic [DW-1:0] v;
      op = $urandom_range(0, 6);
      v  = DW'($urandom);
      case (op)
        0: begin
          startIrq = irqCount;
          hostWrite(1'b0, v, 1'b1); mInFull = 1; mIn = v;
          chk("R3 random irq", irqCount - startIrq, 1);
        end
        1: begin hostWrite(1'b1, v, 1'b1); mCmd = v; end
        2: hostWrite(v[0], v, 1'b0);
        3: begin
          hostRead(1'b0, 1'b1, rd, oe);
          chk("R8 random read data", rd, mOut);
          mOutFull = 0;
        end
        4: begin
          hostRead(1'b1, 1'b1, rd, oe);
          chk("R9 random status", rd, expStatus(mInFull, mOutFull));
        end
        5: begin cpuRead(); mInFull = 0; end
        default: begin cpuWrite(v); mOut = v; mOutFull = 1; end
      endcase
      checkModel("random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule